// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the word address for every access of a synchronous memory that supports four-beat bursts. A burst is opened by one of two active-low start strobes: a processor-side strobe and a controller-side strobe. Each strobe loads the externally supplied address. After that, a burst-advance input steps the low address bits from beat to beat, in either linear or interleaved order. The upper address bits stay fixed for the whole burst.

The two strobes treat the active-low chip enable differently. When the chip enable is inactive, the processor strobe is masked and has no effect. A controller strobe given while the chip enable is inactive produces a deselect cycle and ends the current access. Once a burst is running with both strobes idle, stepping and suspending no longer depend on the chip enable.

All outputs are registered. The address and the flags reflect the inputs sampled at the most recent rising clock edge. Reset is synchronous and active high.

Top module: `burst_seq`

## Requirements
- R1: During a burst, address bits above the low BEAT_W bits keep the value loaded at the start edge, and no step or suspend changes them.
- R2: In linear order, the low bits on beat k equal (start + k) modulo 2^BEAT_W. With the default BEAT_W of 2, a start of 01 gives 01, 10, 11, 00.
- R3: In interleaved order, the low bits on beat k equal start XOR k. A start of 01 gives 01, 00, 11, 10.
- R4: order_sel = 0 selects linear order and order_sel = 1 selects interleaved order. The value is captured on the start edge, and changes of order_sel during a burst are ignored until the next start.
- R5: When ps_n = 0 and ce1_n = 0 on an edge, ext_addr is loaded and the beat count is cleared. After that edge, addr_o = ext_addr, new_o = 1 and live_o = 1.
- R6: When cs_n = 0 and ce1_n = 0 on an edge, ext_addr is loaded in the same way. When ps_n = 0 and ce1_n = 1, the processor strobe is ignored and the edge behaves as if ps_n were 1.
- R7: When cs_n = 0 and ce1_n = 1 on an edge, a deselect cycle follows: desel_o = 1, live_o = 0, new_o = 0, and addr_o keeps its previous value.
- R8: During a burst with both strobes effectively idle and adv_n = 0, the beat count advances by one. After the last beat it wraps within the same aligned block. new_o and wait_o are 0 on such a cycle.
- R9: During a burst with both strobes effectively idle and adv_n = 1, addr_o repeats unchanged and wait_o = 1.
- R10: A burst in progress steps or suspends the same way whatever the value of ce1_n, provided no strobe is effective.
- R11: With no burst live and no strobe effective, all flags stay 0 and addr_o holds its value.
- R12: After reset, addr_o = 0 and every flag is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_addr | input | AW | Address loaded when a burst starts |
| ps_n | input | 1 | Processor start strobe, active low, masked by ce1_n |
| cs_n | input | 1 | Controller start strobe, active low |
| adv_n | input | 1 | Burst advance, active low; high suspends |
| ce1_n | input | 1 | Chip enable, active low |
| order_sel | input | 1 | 0 = linear, 1 = interleaved burst order |
| addr_o | output | AW | Current word address |
| new_o | output | 1 | This cycle starts a new access |
| live_o | output | 1 | An access (new or continued) is in progress |
| wait_o | output | 1 | Suspended beat, address repeated |
| desel_o | output | 1 | Deselect cycle |

## Verification
Every result appears one edge after the inputs that cause it. The bench drives inputs on the falling edge, lets one rising edge pass, and samples shortly after that edge. At the same point it updates its behavioural model with the inputs it has just applied, so expected and actual values always refer to the same edge. Directed sequences cover the order, masking, wrap, suspend and capture corner cases. A long random run then compares all five outputs on every clock.

// File: rtl/bseq_pkg.sv
package bseq_pkg;

  // Action decoded for one clock edge
  typedef enum logic [2:0] {
    ACT_IDLE  = 3'd0,
    ACT_LOAD  = 3'd1,
    ACT_DESEL = 3'd2,
    ACT_STEP  = 3'd3,
    ACT_HOLD  = 3'd4
  } bseq_act_e;

endpackage

// File: rtl/bseq_strobe_dec.sv
module bseq_strobe_dec
  import bseq_pkg::*;
(
  input  logic      ps_n,
  input  logic      cs_n,
  input  logic      adv_n,
  input  logic      ce1_n,
  input  logic      live,
  output bseq_act_e act
);

  logic ps_eff;

  // processor strobe only counts while the chip is enabled
  assign ps_eff = ~ps_n & ~ce1_n;

  always_comb begin
    if (ps_eff)
      act = ACT_LOAD;
    else if (!cs_n)
      act = ce1_n ? ACT_DESEL : ACT_LOAD;
    else if (!live)
      act = ACT_IDLE;
    else if (adv_n)
      act = ACT_HOLD;
    else
      act = ACT_STEP;
  end

endmodule

// File: rtl/bseq_beat_ctr.sv
module bseq_beat_ctr
  import bseq_pkg::*;
#(
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  bseq_act_e         act,
  input  logic [BEAT_W-1:0] load_low,
  input  logic              load_ord,
  output logic [BEAT_W-1:0] nxt_start,
  output logic [BEAT_W-1:0] nxt_beat,
  output logic              nxt_ord,
  output logic              live_q
);

  logic [BEAT_W-1:0] start_q;
  logic [BEAT_W-1:0] beat_q;
  logic              ord_q;
  logic              nxt_live;

  always_comb begin
    nxt_start = start_q;
    nxt_beat  = beat_q;
    nxt_ord   = ord_q;
    nxt_live  = live_q;
    unique case (act)
      ACT_LOAD: begin
        nxt_start = load_low;
        nxt_beat  = '0;
        nxt_ord   = load_ord;
        nxt_live  = 1'b1;
      end
      ACT_DESEL: nxt_live = 1'b0;
      ACT_STEP:  nxt_beat = beat_q + BEAT_W'(1);
      default:   ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q <= '0;
      beat_q  <= '0;
      ord_q   <= 1'b0;
      live_q  <= 1'b0;
    end else begin
      start_q <= nxt_start;
      beat_q  <= nxt_beat;
      ord_q   <= nxt_ord;
      live_q  <= nxt_live;
    end
  end

endmodule

// File: rtl/bseq_addr_form.sv
module bseq_addr_form #(
  parameter int BEAT_W = 2
) (
  input  logic [BEAT_W-1:0] start,
  input  logic [BEAT_W-1:0] beat,
  input  logic              ileave,
  output logic [BEAT_W-1:0] low
);

  logic [BEAT_W-1:0] lin_sum;

  // linear order: wraps naturally in BEAT_W bits
  assign lin_sum = start + beat;

  for (genvar b = 0; b < BEAT_W; b++) begin : g_bit
    assign low[b] = ileave ? (start[b] ^ beat[b]) : lin_sum[b];
  end

endmodule

// File: rtl/burst_seq.sv
module burst_seq
  import bseq_pkg::*;
#(
  parameter int AW     = 16,
  parameter int BEAT_W = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] ext_addr,
  input  logic          ps_n,
  input  logic          cs_n,
  input  logic          adv_n,
  input  logic          ce1_n,
  input  logic          order_sel,
  output logic [AW-1:0] addr_o,
  output logic          new_o,
  output logic          live_o,
  output logic          wait_o,
  output logic          desel_o
);

  localparam int UW = AW - BEAT_W;

  bseq_act_e         act;
  logic              live_q;
  logic [BEAT_W-1:0] nxt_start;
  logic [BEAT_W-1:0] nxt_beat;
  logic              nxt_ord;
  logic [BEAT_W-1:0] nxt_low;
  logic [UW-1:0]     nxt_up;

  bseq_strobe_dec u_dec (
    .ps_n  (ps_n),
    .cs_n  (cs_n),
    .adv_n (adv_n),
    .ce1_n (ce1_n),
    .live  (live_q),
    .act   (act)
  );

  bseq_beat_ctr #(.BEAT_W(BEAT_W)) u_ctr (
    .clk       (clk),
    .rst       (rst),
    .act       (act),
    .load_low  (ext_addr[BEAT_W-1:0]),
    .load_ord  (order_sel),
    .nxt_start (nxt_start),
    .nxt_beat  (nxt_beat),
    .nxt_ord   (nxt_ord),
    .live_q    (live_q)
  );

  bseq_addr_form #(.BEAT_W(BEAT_W)) u_form (
    .start  (nxt_start),
    .beat   (nxt_beat),
    .ileave (nxt_ord),
    .low    (nxt_low)
  );

  assign nxt_up = (act == ACT_LOAD) ? ext_addr[AW-1:BEAT_W] : addr_o[AW-1:BEAT_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_o  <= '0;
      new_o   <= 1'b0;
      wait_o  <= 1'b0;
      desel_o <= 1'b0;
    end else begin
      // a deselect or idle edge leaves the address where it was
      if (act == ACT_LOAD || act == ACT_STEP)
        addr_o <= {nxt_up, nxt_low};
      new_o   <= (act == ACT_LOAD);
      wait_o  <= (act == ACT_HOLD);
      desel_o <= (act == ACT_DESEL);
    end
  end

  assign live_o = live_q;

endmodule

// File: rtl/bseq_checker.sv
module bseq_checker #(
  parameter int AW     = 16,
  parameter int BEAT_W = 2
) (
  input logic          clk,
  input logic          rst,
  input logic          ps_n,
  input logic          cs_n,
  input logic          ce1_n,
  input logic [AW-1:0] addr_o,
  input logic          new_o,
  input logic          live_o,
  input logic          wait_o,
  input logic          desel_o
);

  AST_NEW_IS_LIVE: assert property (@(posedge clk) disable iff (rst)
    new_o |-> live_o); // R5

  AST_UPPER_HELD: assert property (@(posedge clk) disable iff (rst)
    (live_o && !new_o) |-> (addr_o[AW-1:BEAT_W] == $past(addr_o[AW-1:BEAT_W]))); // R1

  AST_MASKED_PS: assert property (@(posedge clk) disable iff (rst)
    (!live_o && !ps_n && ce1_n && cs_n) |=> (!live_o && !new_o)); // R6

  AST_DESEL_CMD: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && ce1_n && !(!ps_n && !ce1_n)) |=> (desel_o && !live_o)); // R7

  AST_WAIT_REPEAT: assert property (@(posedge clk) disable iff (rst)
    wait_o |-> $stable(addr_o)); // R9

  AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (rst)
    $onehot0({new_o, wait_o, desel_o})); // R8

endmodule

bind burst_seq bseq_checker #(.AW(AW), .BEAT_W(BEAT_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .ps_n    (ps_n),
  .cs_n    (cs_n),
  .ce1_n   (ce1_n),
  .addr_o  (addr_o),
  .new_o   (new_o),
  .live_o  (live_o),
  .wait_o  (wait_o),
  .desel_o (desel_o)
);

// File: tb/sim_burst_seq.sv
`timescale 1ns/1ps
module sim_burst_seq;

  localparam int AW     = 16;
  localparam int BEAT_W = 2;
  localparam int NB     = 1 << BEAT_W;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] ext_addr = '0;
  logic          ps_n = 1'b1, cs_n = 1'b1, adv_n = 1'b1, ce1_n = 1'b1, order_sel = 1'b0;
  logic [AW-1:0] addr_o;
  logic          new_o, live_o, wait_o, desel_o;

  int checks = 0;
  int errors = 0;

  // reference model state
  int m_up, m_start, m_beat, m_ord, m_live, m_addr, m_new, m_wait, m_desel;

  always #2 clk = ~clk;

  burst_seq #(.AW(AW), .BEAT_W(BEAT_W)) u0 (
    .clk(clk), .rst(rst), .ext_addr(ext_addr), .ps_n(ps_n), .cs_n(cs_n),
    .adv_n(adv_n), .ce1_n(ce1_n), .order_sel(order_sel), .addr_o(addr_o),
    .new_o(new_o), .live_o(live_o), .wait_o(wait_o), .desel_o(desel_o)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic int low_of(int st, int bt, int od);
    if (od != 0) return st ^ bt;
    return (st + bt) % NB;
  endfunction

  task automatic model_edge(input int ps, input int cs, input int adv, input int ce,
                            input int ord, input int ea);
    int ps_ok;
    ps_ok = (ps == 0 && ce == 0);
    m_new = 0; m_wait = 0; m_desel = 0;
    if (ps_ok || (cs == 0 && ce == 0)) begin
      m_up = ea / NB; m_start = ea % NB; m_beat = 0; m_ord = ord; m_live = 1; m_new = 1;
      m_addr = m_up * NB + low_of(m_start, m_beat, m_ord);
    end else if (cs == 0) begin
      m_live = 0; m_desel = 1;
    end else if (m_live != 0) begin
      if (adv != 0) m_wait = 1;
      else begin
        m_beat = (m_beat + 1) % NB;
        m_addr = m_up * NB + low_of(m_start, m_beat, m_ord);
      end
    end
  endtask

  task automatic step(input int ps, input int cs, input int adv, input int ce,
                      input int ord, input int ea, input string tag);
    @(negedge clk);
    ps_n = ps[0]; cs_n = cs[0]; adv_n = adv[0]; ce1_n = ce[0];
    order_sel = ord[0]; ext_addr = ea[AW-1:0];
    @(posedge clk);
    #1;
    model_edge(ps, cs, adv, ce, ord, ea);
    chk(tag, "addr",  int'(addr_o),  m_addr);
    chk(tag, "new",   int'(new_o),   m_new);
    chk(tag, "live",  int'(live_o),  m_live);
    chk(tag, "wait",  int'(wait_o),  m_wait);
    chk(tag, "desel", int'(desel_o), m_desel);
  endtask

  initial begin : watchdog
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    m_up = 0; m_start = 0; m_beat = 0; m_ord = 0; m_live = 0;
    m_addr = 0; m_new = 0; m_wait = 0; m_desel = 0;
    repeat (3) @(posedge clk);
    #1;
    chk("R12", "addr", int'(addr_o), 0);
    chk("R12", "flags", int'({new_o, live_o, wait_o, desel_o}), 0);
    @(negedge clk); rst = 1'b0;

    step(1, 1, 1, 1, 0, 'h1234, "R11 idle");
    // linear from 01
    step(0, 1, 1, 0, 0, 'h2A41, "R5 R2 load");
    for (int i = 0; i < 5; i++) step(1, 1, 0, 0, 0, 'h0, "R2 R8 R1 linear wrap");
    // interleaved from 01 by controller strobe; order change mid-burst ignored
    step(1, 0, 1, 0, 1, 'h7F3D, "R6 R4 load");
    step(1, 1, 0, 0, 0, 'h0, "R3 R4 step");
    step(1, 1, 0, 0, 0, 'h0, "R3 step");
    step(1, 1, 1, 0, 0, 'h0, "R9 suspend");
    step(1, 1, 0, 1, 0, 'h0, "R10 R3 step ce off");
    step(0, 1, 1, 1, 0, 'h5555, "R6 R10 R9 masked ps");
    step(0, 1, 0, 1, 0, 'h5555, "R6 R10 masked ps step");
    // deselect by controller strobe, then masked ps while idle
    step(1, 0, 0, 1, 0, 'h1111, "R7 deselect");
    step(0, 1, 0, 1, 0, 'h2222, "R6 R11 masked idle");
    step(1, 1, 0, 0, 0, 'h0, "R11 idle adv");
    // both strobes low: load
    step(0, 0, 1, 0, 1, 'hBEE2, "R5 both low");
    for (int i = 0; i < 4; i++) step(1, 1, 0, 0, 1, 'h0, "R3 interleave from 10");
    step(0, 0, 1, 1, 0, 'h3333, "R7 masked ps cs desel");

    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom;
      step((r[3:0] == 0) ? 0 : 1, (r[7:4] == 0) ? 0 : 1, int'(r[8]), int'(r[9]),
           int'(r[10]), int'($urandom % (1 << AW)), "R1 R2 R3 R8 R9 random");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule